// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is a single 16-bit timer channel with an 8-bit register port. A free-running prescaler turns the system clock into a count tick. Its ratio and its active edge come from the control register. The counter advances on each tick while an external run bit, taken from a start register shared between channels, is high. When the run bit is low the counter holds its value.

Two 16-bit compare registers, A and B, are checked against the counter on every tick. A match sets a sticky status flag and applies the programmed action to the matching compare output. If that compare is the selected clear source, the match also restarts the counter. Counter wrap-around sets a third flag. An interrupt line reports the OR of the flags that are enabled. Software clears a flag with a two-step protocol: it first reads the flag as 1, then writes 0 to it.

The 16-bit registers take two byte addresses each. The high byte is at the lower address.

Top module: `match_timer_ch`

## Requirements
- R1: Byte addresses are: control 0, mode 1, output control 2, interrupt enable 4, status 5, counter 6 (high byte) and 7 (low byte), compare A 8/9 and compare B 10/11, high byte first. Unmapped addresses read 0. Read data is registered and is valid in the cycle after the read strobe. After reset the counter, control, output control, enable and status registers read 0, and both compare registers read 0xFFFF.
- R2: Control bits 2:0 select the prescale ratio: 0 gives /1, 1 gives /4, 2 gives /16 and 3 gives /64. Codes 4 to 7 produce no ticks, so the counter does not move.
- R3: Control bits 4:3 select the edge of the prescaled clock that counts: 0 is rising, 1 is falling, and 2 or 3 is both edges. Counting on both edges doubles the count rate of a divided clock.
- R4: The counter advances only while run_en is 1. With run_en at 0 the counter holds its value.
- R5: Control bits 7:5 select the clear source: 1 is compare A and 2 is compare B. Every other code, including 3, never clears the counter. With a selected compare value C, the counter runs 0..C and the period is C+1 ticks.
- R6: A tick with the counter at 0xFFFF and no clear wraps the counter to 0 and sets the overflow flag.
- R7: A bus write to a counter byte in the same cycle as a tick takes priority: the written value is stored and the tick is dropped.
- R8: Output control bits 3:0 hold the action code for output A and bits 7:4 hold it for output B. Writing the register drives the output to 0 for codes 1 to 3 and to 1 for codes 5 to 7. Code 0 and codes 4, 8 to 15 leave the output unchanged.
- R9: On a compare match, code 1 or 5 clears the output, code 2 or 6 sets it, and code 3 or 7 toggles it.
- R10: Status bit 0 is the compare-A flag, bit 1 the compare-B flag and bit 4 the overflow flag. Each flag is set by its event and stays set until software clears it.
- R11: Writing 0 to a flag clears it only if a status read has already returned that flag as 1. Writing 1 leaves the flag unchanged.
- R12: Interrupt-enable bits 0, 1 and 4 gate the A, B and overflow flags. irq is a registered OR of the enabled flags and follows them one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| run_en | input | 1 | This channel's bit of the shared start register |
| cmp_out_a | output | 1 | Compare output A |
| cmp_out_b | output | 1 | Compare output B |
| irq | output | 1 | Interrupt request |

## Verification
A tick, a match or a bus write updates the counter, the flags and the outputs at the same clock edge. irq follows one edge later, and read data is due one edge after the read strobe. The bench drives inputs on falling edges and holds run_en high for exactly N rising edges. Each counting window lasts a whole number of prescaler periods, so the expected count is N divided by the ratio whatever the prescaler phase. Every read samples on the falling edge that follows the edge which registers the data, and outputs and irq are sampled only after at least one full idle cycle.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_MODE  = 4'd1;
  localparam logic [ADDR_W-1:0] A_IOCTL = 4'd2;
  localparam logic [ADDR_W-1:0] A_IEN   = 4'd4;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd5;
  localparam logic [ADDR_W-1:0] A_CNT_H = 4'd6;
  localparam logic [ADDR_W-1:0] A_CNT_L = 4'd7;
  localparam logic [ADDR_W-1:0] A_CPA_H = 4'd8;
  localparam logic [ADDR_W-1:0] A_CPA_L = 4'd9;
  localparam logic [ADDR_W-1:0] A_CPB_H = 4'd10;
  localparam logic [ADDR_W-1:0] A_CPB_L = 4'd11;

  typedef enum logic [1:0] {CLR_NONE, CLR_CMP_A, CLR_CMP_B} clr_src_e;
  typedef enum logic [1:0] {EDGE_RISE, EDGE_FALL, EDGE_BOTH} edge_sel_e;

  localparam int EV_A   = 0;
  localparam int EV_B   = 1;
  localparam int EV_OVF = 2;
  localparam int NUM_EV = 3;
endpackage

// File: rtl/match_timer_prescaler.sv
module match_timer_prescaler #(
  parameter int LOG_STEP = 2,
  parameter int NUM_CODES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [2:0] div_code,
  input  logic [1:0] edge_code,
  output logic       tick
);
  import match_timer_pkg::*;
  localparam int PSC_W = LOG_STEP * (NUM_CODES - 1);

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] mask;
  logic             rise_hit, fall_hit, valid;
  edge_sel_e        esel;

  always_ff @(posedge clk) begin
    if (rst) psc_q <= '0;
    else     psc_q <= psc_q + 1'b1;
  end

  always_comb begin
    valid = (int'(div_code) < NUM_CODES);
    mask  = '0;
    if (valid && div_code != 3'd0)
      mask = {PSC_W{1'b1}} >> (PSC_W - LOG_STEP * int'(div_code));
    rise_hit = ((psc_q & mask) == (mask >> 1));
    fall_hit = ((psc_q & mask) == mask);
    case (edge_code)
      2'd0:    esel = EDGE_RISE;
      2'd1:    esel = EDGE_FALL;
      default: esel = EDGE_BOTH;
    endcase
    tick = 1'b0;
    if (run && valid) begin
      if (div_code == 3'd0) tick = 1'b1;
      else begin
        case (esel)
          EDGE_RISE: tick = rise_hit;
          EDGE_FALL: tick = fall_hit;
          default:   tick = rise_hit | fall_hit;
        endcase
      end
    end
  end

  a_r2_reserved_no_tick: assert property (@(posedge clk) disable iff (rst)
    (div_code >= 3'(NUM_CODES)) |-> !tick);
endmodule

// File: rtl/match_timer_counter.sv
module match_timer_counter #(
  parameter int CNT_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick,
  input  match_timer_pkg::clr_src_e    clr_sel,
  input  logic [CNT_W-1:0]             cmp_a,
  input  logic [CNT_W-1:0]             cmp_b,
  input  logic                         wr_hi,
  input  logic                         wr_lo,
  input  logic [7:0]                   wdata,
  output logic [CNT_W-1:0]             cnt,
  output logic                         ev_a,
  output logic                         ev_b,
  output logic                         ev_ovf
);
  import match_timer_pkg::*;
  localparam int HI_W = CNT_W - 8;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_clr;

  always_comb begin
    cnt_d  = cnt_q;
    ev_a   = 1'b0;
    ev_b   = 1'b0;
    ev_ovf = 1'b0;
    do_clr = 1'b0;
    if (wr_hi || wr_lo) begin
      cnt_d = {wr_hi ? wdata[HI_W-1:0] : cnt_q[CNT_W-1:8],
               wr_lo ? wdata : cnt_q[7:0]};
    end else if (tick) begin
      ev_a   = (cnt_q == cmp_a);
      ev_b   = (cnt_q == cmp_b);
      do_clr = (clr_sel == CLR_CMP_A && ev_a) || (clr_sel == CLR_CMP_B && ev_b);
      if (do_clr) cnt_d = '0;
      else begin
        cnt_d  = cnt_q + 1'b1;
        ev_ovf = &cnt_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  a_r7_write_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wr_hi) |=> (cnt_q[7:0] == $past(wdata)));
  a_r6_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    ev_ovf |=> (cnt_q == '0));
endmodule

// File: rtl/match_timer_flags.sv
module match_timer_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_ev,
  input  logic         rd_stat,
  input  logic         wr_stat,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] flags
);
  logic [N-1:0] flag_q, armed_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic clr;
    assign clr = wr_stat && armed_q[i] && !wbits[i];
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[i]  <= 1'b0;
        armed_q[i] <= 1'b0;
      end else begin
        if (set_ev[i])  flag_q[i] <= 1'b1;
        else if (clr)   flag_q[i] <= 1'b0;
        if (rd_stat)    armed_q[i] <= flag_q[i];
        else if (clr)   armed_q[i] <= 1'b0;
      end
    end
  end

  assign flags = flag_q;

  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    !wr_stat |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  a_r11_write_one_keeps: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && (&wbits)) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

// File: rtl/match_timer_output.sv
module match_timer_output (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] code,
  input  logic       code_wr,
  input  logic [3:0] new_code,
  input  logic       match,
  output logic       level
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else if (code_wr) begin
      if (new_code inside {4'd1, 4'd2, 4'd3}) lvl_q <= 1'b0;
      else if (new_code inside {4'd5, 4'd6, 4'd7}) lvl_q <= 1'b1;
    end else if (match && !code[3] && code[1:0] != 2'd0) begin
      case (code[1:0])
        2'd1:    lvl_q <= 1'b0;
        2'd2:    lvl_q <= 1'b1;
        default: lvl_q <= ~lvl_q;
      endcase
    end
  end

  assign level = lvl_q;

  a_r8_init_high: assert property (@(posedge clk) disable iff (rst)
    (code_wr && new_code inside {4'd5, 4'd6, 4'd7}) |=> level);
  a_r8_init_low: assert property (@(posedge clk) disable iff (rst)
    (code_wr && new_code inside {4'd1, 4'd2, 4'd3}) |=> !level);
endmodule

// File: rtl/match_timer_ch.sv
module match_timer_ch #(
  parameter int CNT_W = 16,
  parameter int PSC_LOG_STEP = 2,
  parameter int PSC_CODES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       run_en,
  output logic       cmp_out_a,
  output logic       cmp_out_b,
  output logic       irq
);
  import match_timer_pkg::*;
  localparam int NOUT = 2;

  logic [7:0]       ctrl_q, mode_q, ioc_q, ien_q, rdata_q;
  logic [CNT_W-1:0] cpa_q, cpb_q, cnt;
  logic             tick, ev_a, ev_b, ev_ovf, irq_q;
  logic [NUM_EV-1:0] flags, ien_bits;
  logic             wr_cnt_h, wr_cnt_l, wr_ioc;
  clr_src_e         clr_sel;
  logic [NOUT-1:0]  out_lvl, out_match;

  always_comb begin
    case (ctrl_q[7:5])
      3'd1:    clr_sel = CLR_CMP_A;
      3'd2:    clr_sel = CLR_CMP_B;
      default: clr_sel = CLR_NONE;
    endcase
  end

  assign wr_cnt_h = bus_wr && bus_addr == A_CNT_H;
  assign wr_cnt_l = bus_wr && bus_addr == A_CNT_L;
  assign wr_ioc   = bus_wr && bus_addr == A_IOCTL;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      mode_q <= '0;
      ioc_q  <= '0;
      ien_q  <= '0;
      cpa_q  <= '1;
      cpb_q  <= '1;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL:  ctrl_q <= bus_wdata;
        A_MODE:  mode_q <= bus_wdata;
        A_IOCTL: ioc_q  <= bus_wdata;
        A_IEN:   ien_q  <= bus_wdata;
        A_CPA_H: cpa_q[CNT_W-1:8] <= bus_wdata[CNT_W-9:0];
        A_CPA_L: cpa_q[7:0] <= bus_wdata;
        A_CPB_H: cpb_q[CNT_W-1:8] <= bus_wdata[CNT_W-9:0];
        A_CPB_L: cpb_q[7:0] <= bus_wdata;
        default: ;
      endcase
    end
  end

  match_timer_prescaler #(.LOG_STEP(PSC_LOG_STEP), .NUM_CODES(PSC_CODES)) u_psc (
    .clk(clk), .rst(rst), .run(run_en),
    .div_code(ctrl_q[2:0]), .edge_code(ctrl_q[4:3]), .tick(tick)
  );

  match_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .clr_sel(clr_sel),
    .cmp_a(cpa_q), .cmp_b(cpb_q), .wr_hi(wr_cnt_h), .wr_lo(wr_cnt_l),
    .wdata(bus_wdata), .cnt(cnt), .ev_a(ev_a), .ev_b(ev_b), .ev_ovf(ev_ovf)
  );

  match_timer_flags #(.N(NUM_EV)) u_flags (
    .clk(clk), .rst(rst),
    .set_ev({ev_ovf, ev_b, ev_a}),
    .rd_stat(bus_rd && bus_addr == A_STAT),
    .wr_stat(bus_wr && bus_addr == A_STAT),
    .wbits({bus_wdata[4], bus_wdata[1], bus_wdata[0]}),
    .flags(flags)
  );

  assign out_match = {ev_b, ev_a};

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    match_timer_output u_out (
      .clk(clk), .rst(rst),
      .code(ioc_q[4*i +: 4]), .code_wr(wr_ioc), .new_code(bus_wdata[4*i +: 4]),
      .match(out_match[i]), .level(out_lvl[i])
    );
  end

  assign cmp_out_a = out_lvl[0];
  assign cmp_out_b = out_lvl[1];

  assign ien_bits = {ien_q[4], ien_q[1], ien_q[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      irq_q <= |(flags & ien_bits);
      if (bus_rd) begin
        case (bus_addr)
          A_CTRL:  rdata_q <= ctrl_q;
          A_MODE:  rdata_q <= mode_q;
          A_IOCTL: rdata_q <= ioc_q;
          A_IEN:   rdata_q <= ien_q;
          A_STAT:  rdata_q <= {3'b0, flags[EV_OVF], 2'b0, flags[EV_B], flags[EV_A]};
          A_CNT_H: rdata_q <= 8'(cnt[CNT_W-1:8]);
          A_CNT_L: rdata_q <= cnt[7:0];
          A_CPA_H: rdata_q <= 8'(cpa_q[CNT_W-1:8]);
          A_CPA_L: rdata_q <= cpa_q[7:0];
          A_CPB_H: rdata_q <= 8'(cpb_q[CNT_W-1:8]);
          A_CPB_L: rdata_q <= cpb_q[7:0];
          default: rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign irq = irq_q;

  a_r4_freeze: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !wr_cnt_h && !wr_cnt_l) |=> $stable(cnt));
  a_r12_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    ((flags & ien_bits) == '0) |=> !irq);
  a_r5_clear_a: assert property (@(posedge clk) disable iff (rst)
    (clr_sel == CLR_CMP_A && ev_a && !wr_cnt_h && !wr_cnt_l) |=> (cnt == '0));
endmodule

// File: tb/match_timer_ch_tb_top.sv
`timescale 1ns/1ps
module match_timer_ch_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, run_en = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cmp_out_a, cmp_out_b, irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  match_timer_ch dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .run_en(run_en),
    .cmp_out_a(cmp_out_a), .cmp_out_b(cmp_out_b), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] d);
    logic [7:0] h, l;
    rd(a, h);
    rd(a + 4'd1, l);
    d = {h, l};
  endtask

  task automatic run(input int n);
    @(negedge clk);
    run_en = 1'b1;
    repeat (n) @(negedge clk);
    run_en = 1'b0;
  endtask

  task automatic zero_cnt();
    wr(4'd6, 8'h00);
    wr(4'd7, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d; logic [15:0] w;
    rd(4'd0, d);  chk("R1 ctrl reset", 16'(d), 16'h0);
    rd16(4'd8, w); chk("R1 cmpA reset", w, 16'hFFFF);
    rd16(4'd10, w); chk("R1 cmpB reset", w, 16'hFFFF);
    rd16(4'd6, w); chk("R1 cnt reset", w, 16'h0);
    rd(4'd5, d);  chk("R1 status reset", 16'(d), 16'h0);
    rd(4'd3, d);  chk("R1 unmapped", 16'(d), 16'h0);
    chk("R1 outputs reset", {14'b0, cmp_out_b, cmp_out_a}, 16'h0);
    chk("R12 irq reset", 16'(irq), 16'h0);
  endtask

  task automatic t_prescale(input logic [7:0] ctrl, input int n, input logic [15:0] exp, input string req);
    logic [15:0] w;
    wr(4'd0, ctrl);
    zero_cnt();
    run(n);
    rd16(4'd6, w);
    chk(req, w, exp);
  endtask

  task automatic t_freeze();
    logic [15:0] a, b;
    wr(4'd0, 8'h00);
    zero_cnt();
    run(7);
    rd16(4'd6, a);
    repeat (20) @(negedge clk);
    rd16(4'd6, b);
    chk("R4 run count", a, 16'd7);
    chk("R4 frozen", b, 16'd7);
  endtask

  task automatic t_write_priority();
    logic [7:0] d;
    wr(4'd0, 8'h00);
    zero_cnt();
    @(negedge clk); run_en = 1'b1;
    repeat (3) @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'd7; bus_wdata = 8'h40;
    @(negedge clk);
    bus_wr = 1'b0; run_en = 1'b0;
    rd(4'd7, d);
    chk("R7 write beats tick", 16'(d), 16'h0040);
  endtask

  task automatic t_match_clear_a();
    logic [7:0] d;
    wr(4'd0, 8'h20);
    wr(4'd8, 8'h00); wr(4'd9, 8'h09);
    wr(4'd10, 8'h00); wr(4'd11, 8'h03);
    wr(4'd2, 8'h53);
    @(negedge clk);
    chk("R8 init A low", 16'(cmp_out_a), 16'h0);
    chk("R8 init B high", 16'(cmp_out_b), 16'h1);
    wr(4'd4, 8'h01);
    zero_cnt();
    run(15);
    rd(4'd7, d);
    chk("R5 clear on A period", 16'(d), 16'd5);
    chk("R9 toggle A", 16'(cmp_out_a), 16'h1);
    chk("R9 clear B", 16'(cmp_out_b), 16'h0);
    rd(4'd5, d);
    chk("R10 flags A and B", 16'(d), 16'h03);
    chk("R12 irq enabled A", 16'(irq), 16'h1);
    wr(4'd5, 8'h02);
    rd(4'd5, d);
    chk("R11 write0 clears A, write1 keeps B", 16'(d), 16'h02);
  endtask

  task automatic t_clear_b_and_sync();
    logic [7:0] d;
    wr(4'd0, 8'h40);
    zero_cnt();
    run(10);
    rd(4'd7, d);
    chk("R5 clear on B period 4", 16'(d), 16'd2);
    wr(4'd0, 8'h60);
    zero_cnt();
    run(15);
    rd(4'd7, d);
    chk("R5 code 3 no clear", 16'(d), 16'd15);
    wr(4'd2, 8'h62);
    @(negedge clk);
    chk("R8 code 2 init low", 16'(cmp_out_a), 16'h0);
    chk("R8 code 6 init high", 16'(cmp_out_b), 16'h1);
    wr(4'd2, 8'h00);
    @(negedge clk);
    chk("R8 code 0 retains", {14'b0, cmp_out_b, cmp_out_a}, 16'h2);
  endtask

  task automatic t_overflow();
    logic [7:0] d;
    wr(4'd4, 8'h10);
    rd(4'd5, d);
    wr(4'd5, 8'h00);
    @(negedge clk);
    chk("R12 irq low when flags clear", 16'(irq), 16'h0);
    wr(4'd0, 8'h00);
    wr(4'd6, 8'hFF); wr(4'd7, 8'hFE);
    run(2);
    @(negedge clk);
    rd(4'd6, d);
    chk("R6 wrap to zero", 16'(d), 16'h0);
    chk("R12 irq from overflow", 16'(irq), 16'h1);
    wr(4'd5, 8'h00);
    rd(4'd5, d);
    chk("R11 unread flag not cleared", 16'(d), 16'h10);
    wr(4'd5, 8'h00);
    rd(4'd5, d);
    chk("R6 overflow flag cleared after read", 16'(d), 16'h00);
    @(negedge clk);
    chk("R12 irq drops", 16'(irq), 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_prescale(8'h00, 40, 16'd40, "R2 div1");
    t_prescale(8'h01, 64, 16'd16, "R2 div4");
    t_prescale(8'h02, 128, 16'd8, "R2 div16");
    t_prescale(8'h03, 128, 16'd2, "R2 div64");
    t_prescale(8'h05, 40, 16'd0, "R2 reserved code stops");
    t_prescale(8'h09, 64, 16'd16, "R3 falling div4");
    t_prescale(8'h11, 64, 16'd32, "R3 both edges div4");
    t_prescale(8'h1A, 128, 16'd16, "R3 code3 both div16");
    t_freeze();
    t_write_priority();
    t_match_clear_a();
    t_clear_b_and_sync();
    t_overflow();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule